// File: doc/BRIEF.md
# Redundant Reference Clock Failover Controller

This block supervises two reference clock inputs that feed a downstream PLL. Running on a faster, free-running sampling clock, it looks for an input that has stopped toggling, whether held high or held low, and latches an active-low alarm for that input. It also decides which of the two inputs the external clock multiplexer passes to the PLL, and reports that choice on a reference indicator.

Two control pins set the policy. A primary-select pin names the preferred input. A mode pin chooses between manual selection, where the primary is always used, and automatic selection, where a failed reference is replaced by the other input if that input is healthy. A PLL-bypass pin forces manual behaviour. Alarms stay latched until a falling edge on the active-low alarm-clear pin. That edge clears both alarms and returns the selection to the primary. If both alarms were set when the edge arrived, it returns the selection to input 0 instead.

All control pins are asynchronous to the sampling clock and pass through synchronizers. The PLL, the output dividers and the analog glitch-free multiplexer are outside this block.

Top module: `clk_failover_ctrl`

## Requirements
- R1: An input with no level change for more than TIMEOUT_CYC sampling cycles, whether held high or held low, drives its alarm output (alarm0_n for ref0_in, alarm1_n for ref1_in) low within TIMEOUT_CYC+8 cycles.
- R2: An input that changes level at least every TIMEOUT_CYC sampling cycles never raises its alarm. A gap of TIMEOUT_CYC+1 cycles does raise it.
- R3: A raised alarm stays low after the input recovers, and while alarm_clr_n is held high or held low. Only a high-to-low transition of alarm_clr_n clears it.
- R4: A falling edge of alarm_clr_n drives both alarm outputs high. If at most one alarm was set, it makes the primary (prim_sel: 0 selects ref0_in, 1 selects ref1_in) the selected reference.
- R5: A falling edge of alarm_clr_n taken while both alarms are low selects input 0 whatever prim_sel is. In automatic mode the selection then holds until the next clear or until manual mode is entered.
- R6: mux_sel and ref_ind are 0 when ref0_in is the reference and 1 when ref1_in is. ref_ind follows mux_sel one cycle later. After reset both settle to the prim_sel level, and both alarms read high during and after reset.
- R7: In manual mode (auto_mode low), the primary is the reference even when its alarm is set, and a change of prim_sel moves the reference within 6 cycles.
- R8: In automatic mode (auto_mode high, pll_bypass low), a failure of the current reference moves the selection to the other input if that input has no alarm.
- R9: In automatic mode, a failure of the current reference while the other input is alarmed leaves the selection unchanged.
- R10: After an automatic failover, prim_sel changes do not move the reference until the next alarm clear.
- R11: With pll_bypass high, automatic switching is disabled and the block behaves as in manual mode.
- R12: A failure of the input that took over, while the original input is still alarmed, leaves the selection where it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Free-running sampling clock, faster than the references |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref0_in | input | 1 | Reference clock input 0 (asynchronous) |
| ref1_in | input | 1 | Reference clock input 1 (asynchronous) |
| prim_sel | input | 1 | Primary input choice: 0 = input 0, 1 = input 1 |
| auto_mode | input | 1 | 1 = automatic failover, 0 = manual |
| alarm_clr_n | input | 1 | Falling edge clears alarms and reselects |
| pll_bypass | input | 1 | 1 forces manual behaviour |
| alarm0_n | output | 1 | Active-low latched failure flag of input 0 |
| alarm1_n | output | 1 | Active-low latched failure flag of input 1 |
| ref_ind | output | 1 | Registered indicator of the active reference |
| mux_sel | output | 1 | Select for the external reference multiplexer |

## Verification
The selection logic is driven through a table of scenarios. Each scenario combines a primary choice, a mode, the bypass pin, and which inputs stop, held high or held low. Failing the secondary first and the primary second separates a correct failover from one that ignores the secondary's alarm. Toggling the input with gaps of exactly TIMEOUT_CYC cycles, then TIMEOUT_CYC+1, pins down the detection threshold. Directed sequences then cover latching across recovery, level versus edge clear, a prim_sel change after failover, a second failure on the new reference, and a clear taken with both alarms set.

// File: rtl/cfo_pkg.sv
package cfo_pkg;
   localparam int unsigned NUM_REFS = 2;
   typedef logic [NUM_REFS-1:0] ref_vec_t;
   localparam int unsigned CTL_W = 4;
   typedef struct packed {
      logic bypass;
      logic automode;
      logic prim;
      logic clr_n;
   } ctl_t;
endpackage

// File: rtl/cfo_sync.sv
module cfo_sync #(
   parameter int unsigned WIDTH = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("cfo_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cfo_act_mon.sv
module cfo_act_mon #(
   parameter int unsigned TIMEOUT_CYC = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_async,
   output logic stuck
);
   localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
   localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

   logic          lvl;
   logic          lvl_d;
   logic          edge_seen;
   logic [CW-1:0] idle_cnt;

   cfo_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (ref_async),
      .q    (lvl)
   );

   assign edge_seen = lvl ^ lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_d    <= 1'b0;
         idle_cnt <= '0;
      end else begin
         lvl_d <= lvl;
         if (edge_seen)              idle_cnt <= '0;
         else if (idle_cnt != LIMIT) idle_cnt <= idle_cnt + 1'b1;
      end
   end

   assign stuck = (idle_cnt == LIMIT);
endmodule

// File: rtl/cfo_sel_core.sv
module cfo_sel_core
   import cfo_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr_pls,
   input  logic     prim,
   input  logic     auto_eff,
   input  ref_vec_t stuck,
   output ref_vec_t alarm_q,
   output logic     sel_q,
   output logic     hold_q
);
   ref_vec_t stuck_d;
   ref_vec_t fail_evt;
   ref_vec_t alarm_nx;
   logic     sel_nx;
   logic     hold_nx;
   logic     other;

   assign fail_evt = stuck & ~stuck_d;
   assign other    = ~sel_q;

   always_comb begin
      alarm_nx = alarm_q;
      sel_nx   = sel_q;
      hold_nx  = hold_q;
      if (clr_pls) begin
         alarm_nx = '0;
         if (&alarm_q) begin
            sel_nx  = 1'b0;
            hold_nx = 1'b1;
         end else begin
            sel_nx  = prim;
            hold_nx = 1'b0;
         end
      end else begin
         alarm_nx = alarm_q | stuck;
         if (!auto_eff) begin
            sel_nx  = prim;
            hold_nx = 1'b0;
         end else if (!hold_q) begin
            if (fail_evt[sel_q] && !alarm_q[other] && !stuck[other]) begin
               sel_nx  = other;
               hold_nx = 1'b1;
            end else begin
               sel_nx = prim;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stuck_d <= '0;
         alarm_q <= '0;
         sel_q   <= 1'b0;
         hold_q  <= 1'b0;
      end else begin
         stuck_d <= stuck;
         alarm_q <= alarm_nx;
         sel_q   <= sel_nx;
         hold_q  <= hold_nx;
      end
   end
endmodule

// File: rtl/clk_failover_ctrl.sv
module clk_failover_ctrl
   import cfo_pkg::*;
#(
   parameter int unsigned TIMEOUT_CYC = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_smp,
   input  logic rst_n,
   input  logic ref0_in,
   input  logic ref1_in,
   input  logic prim_sel,
   input  logic auto_mode,
   input  logic alarm_clr_n,
   input  logic pll_bypass,
   output logic alarm0_n,
   output logic alarm1_n,
   output logic ref_ind,
   output logic mux_sel
);
   localparam ctl_t CTL_RST = '{bypass: 1'b0, automode: 1'b0, prim: 1'b0, clr_n: 1'b1};

   generate
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("TIMEOUT_CYC must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   ctl_t     ctl_raw;
   ctl_t     ctl_s;
   logic     clr_d;
   logic     clr_pls;
   logic     prim_s;
   logic     auto_eff;
   ref_vec_t ref_raw;
   ref_vec_t stuck;
   ref_vec_t alarm_q;
   logic     sel_q;
   logic     hold_q;
   logic     ind_q;

   assign ctl_raw = '{bypass: pll_bypass, automode: auto_mode, prim: prim_sel, clr_n: alarm_clr_n};

   cfo_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) i_ctl_sync (
      .clk  (clk_smp),
      .rst_n(rst_n),
      .d    (ctl_raw),
      .q    (ctl_s)
   );

   always_ff @(posedge clk_smp or negedge rst_n) begin
      if (!rst_n) clr_d <= 1'b1;
      else        clr_d <= ctl_s.clr_n;
   end

   assign clr_pls  = clr_d & ~ctl_s.clr_n;
   assign prim_s   = ctl_s.prim;
   assign auto_eff = ctl_s.automode & ~ctl_s.bypass;
   assign ref_raw  = {ref1_in, ref0_in};

   for (genvar g = 0; g < NUM_REFS; g++) begin : g_mon
      cfo_act_mon #(.TIMEOUT_CYC(TIMEOUT_CYC), .SYNC_STAGES(SYNC_STAGES)) i_mon (
         .clk      (clk_smp),
         .rst_n    (rst_n),
         .ref_async(ref_raw[g]),
         .stuck    (stuck[g])
      );
   end

   cfo_sel_core i_core (
      .clk     (clk_smp),
      .rst_n   (rst_n),
      .clr_pls (clr_pls),
      .prim    (prim_s),
      .auto_eff(auto_eff),
      .stuck   (stuck),
      .alarm_q (alarm_q),
      .sel_q   (sel_q),
      .hold_q  (hold_q)
   );

   always_ff @(posedge clk_smp or negedge rst_n) begin
      if (!rst_n) ind_q <= 1'b0;
      else        ind_q <= sel_q;
   end

   assign alarm0_n = ~alarm_q[0];
   assign alarm1_n = ~alarm_q[1];
   assign mux_sel  = sel_q;
   assign ref_ind  = ind_q;
endmodule

// File: rtl/cfo_checker.sv
module cfo_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       clr_pls,
   input logic       prim_s,
   input logic       auto_eff,
   input logic [1:0] stuck,
   input logic       hold_q,
   input logic       alarm0_n,
   input logic       alarm1_n,
   input logic       mux_sel
);
   a_r1_stuck_sets_alarm0: assert property (@(posedge clk) disable iff (!rst_n)
      stuck[0] && !clr_pls |=> !alarm0_n);
   a_r1_stuck_sets_alarm1: assert property (@(posedge clk) disable iff (!rst_n)
      stuck[1] && !clr_pls |=> !alarm1_n);
   a_r3_alarm0_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !alarm0_n && !clr_pls |=> !alarm0_n);
   a_r3_alarm1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !alarm1_n && !clr_pls |=> !alarm1_n);
   a_r4_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pls |=> alarm0_n && alarm1_n);
   a_r5_both_forces_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pls && !alarm0_n && !alarm1_n |=> !mux_sel);
   a_r7_manual_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_eff && !clr_pls |=> mux_sel == $past(prim_s));
   a_r9_target_healthy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_q) && !$past(clr_pls) |-> (mux_sel ? alarm1_n : alarm0_n));
   a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      hold_q && auto_eff && !clr_pls |=> $stable(mux_sel));
endmodule

bind clk_failover_ctrl cfo_checker i_cfo_checker (
   .clk     (clk_smp),
   .rst_n   (rst_n),
   .clr_pls (clr_pls),
   .prim_s  (prim_s),
   .auto_eff(auto_eff),
   .stuck   (stuck),
   .hold_q  (hold_q),
   .alarm0_n(alarm0_n),
   .alarm1_n(alarm1_n),
   .mux_sel (mux_sel)
);

// File: tb/test_clk_failover_ctrl.sv
module test_clk_failover_ctrl;
   localparam int unsigned TO = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref0_in = 1'b0, ref1_in = 1'b0;
   logic prim_sel = 1'b0, auto_mode = 1'b0, alarm_clr_n = 1'b1, pll_bypass = 1'b0;
   logic alarm0_n, alarm1_n, ref_ind, mux_sel;

   int checks = 0;
   int failures = 0;
   logic run0 = 1'b1, run1 = 1'b1, sv0 = 1'b0, sv1 = 1'b0;
   int half0 = 5, half1 = 5;

   always #5 clk = ~clk;

   clk_failover_ctrl #(.TIMEOUT_CYC(TO), .SYNC_STAGES(2)) i_clk_failover_ctrl (
      .clk_smp(clk), .rst_n(rst_n), .ref0_in(ref0_in), .ref1_in(ref1_in),
      .prim_sel(prim_sel), .auto_mode(auto_mode), .alarm_clr_n(alarm_clr_n),
      .pll_bypass(pll_bypass), .alarm0_n(alarm0_n), .alarm1_n(alarm1_n),
      .ref_ind(ref_ind), .mux_sel(mux_sel)
   );

   initial begin
      int c0 = 0;
      forever begin
         @(negedge clk);
         if (run0) begin
            if (c0 >= half0 - 1) begin ref0_in = ~ref0_in; c0 = 0; end
            else c0++;
         end else begin
            ref0_in = sv0; c0 = 0;
         end
      end
   end

   initial begin
      int c1 = 0;
      forever begin
         @(negedge clk);
         if (run1) begin
            if (c1 >= half1 - 1) begin ref1_in = ~ref1_in; c1 = 0; end
            else c1++;
         end else begin
            ref1_in = sv1; c1 = 0;
         end
      end
   end

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_clr();
      alarm_clr_n = 1'b0;
      wait_cyc(4);
      alarm_clr_n = 1'b1;
      wait_cyc(8);
   endtask

   task automatic fresh(input logic p, input logic a, input logic b);
      run0 = 1'b1; run1 = 1'b1; half0 = 5; half1 = 5;
      prim_sel = p; auto_mode = a; pll_bypass = b;
      wait_cyc(30);
      pulse_clr();
      pulse_clr();
   endtask

   // bits: [8]prim [7]auto [6]bypass [5]stop0 [4]stop1 [3]stuck level
   //       [2]expected sel [1]expected alarm0_n [0]expected alarm1_n
   localparam logic [8:0] VEC [8] = '{
      9'b000_000_011, // R7 manual, primary 0, healthy
      9'b100_000_111, // R7 manual, primary 1, healthy
      9'b000_101_001, // R7 R1 manual keeps failed primary 0 (stuck high)
      9'b010_100_101, // R8 auto failover 0 -> 1 (stuck low)
      9'b110_011_010, // R8 auto failover 1 -> 0 (stuck high)
      9'b011_100_001, // R11 bypass keeps failed primary
      9'b110_101_101, // R8 secondary failure does not move reference
      9'b010_110_000  // R9 secondary alarmed first, primary then fails
   };

   initial begin
      // R6 reset state
      prim_sel = 1'b1;
      wait_cyc(3);
      check("R6 alarm0_n in reset", alarm0_n, 1'b1);
      check("R6 alarm1_n in reset", alarm1_n, 1'b1);
      rst_n = 1'b1;
      wait_cyc(8);
      check("R6 ref_ind equals prim after reset", ref_ind, 1'b1);
      check("R6 mux_sel equals prim after reset", mux_sel, 1'b1);
      check("R6 alarm0_n after reset", alarm0_n, 1'b1);

      foreach (VEC[i]) begin
         logic [8:0] v;
         v = VEC[i];
         fresh(v[8], v[7], v[6]);
         sv0 = v[3]; sv1 = v[3];
         if (v[4]) begin run1 = 1'b0; wait_cyc(60); end
         if (v[5]) begin run0 = 1'b0; wait_cyc(60); end
         wait_cyc(4);
         check($sformatf("R8 R9 R11 row %0d mux_sel", i), mux_sel, v[2]);
         check($sformatf("R6 row %0d ref_ind", i), ref_ind, v[2]);
         check($sformatf("R1 row %0d alarm0_n", i), alarm0_n, v[1]);
         check($sformatf("R1 row %0d alarm1_n", i), alarm1_n, v[0]);
      end

      // R2 threshold: gaps of TO cycles tolerated, TO+1 flagged
      fresh(1'b0, 1'b0, 1'b0);
      half0 = TO;
      wait_cyc(300);
      check("R2 gap TO no alarm", alarm0_n, 1'b1);
      half0 = TO + 1;
      wait_cyc(120);
      check("R2 gap TO+1 alarms", alarm0_n, 1'b0);
      half0 = 5;

      // R3 latched across recovery, cleared only by falling edge
      fresh(1'b0, 1'b0, 1'b0);
      sv0 = 1'b0; run0 = 1'b0;
      wait_cyc(60);
      run0 = 1'b1;
      wait_cyc(60);
      check("R3 alarm held after recovery", alarm0_n, 1'b0);
      alarm_clr_n = 1'b0;
      wait_cyc(10);
      check("R3 falling edge clears", alarm0_n, 1'b1);
      sv1 = 1'b1; run1 = 1'b0;
      wait_cyc(60);
      check("R3 alarm set while clear held low", alarm1_n, 1'b0);
      run1 = 1'b1;
      alarm_clr_n = 1'b1;
      wait_cyc(20);
      check("R3 rising edge does not clear", alarm1_n, 1'b0);
      pulse_clr();

      // R10 and R4: failover, primary ignored, clear returns to primary
      fresh(1'b0, 1'b1, 1'b0);
      sv0 = 1'b1; run0 = 1'b0;
      wait_cyc(60);
      check("R8 failover to input 1", mux_sel, 1'b1);
      prim_sel = 1'b1; wait_cyc(10);
      prim_sel = 1'b0; wait_cyc(10);
      check("R10 prim change ignored after failover", mux_sel, 1'b1);
      check("R10 indicator stays after failover", ref_ind, 1'b1);
      run0 = 1'b1;
      wait_cyc(20);
      pulse_clr();
      check("R4 clear returns to primary", mux_sel, 1'b0);
      check("R4 clear releases alarm0_n", alarm0_n, 1'b1);

      // R12 second failure with original still alarmed
      fresh(1'b0, 1'b1, 1'b0);
      sv0 = 1'b0; run0 = 1'b0;
      wait_cyc(60);
      run0 = 1'b1;
      sv1 = 1'b0; run1 = 1'b0;
      wait_cyc(60);
      check("R12 selection stays on input 1", mux_sel, 1'b1);
      check("R12 both alarms low a1", alarm1_n, 1'b0);

      // R5 clear with both alarms forces input 0
      run1 = 1'b1;
      prim_sel = 1'b1;
      wait_cyc(20);
      pulse_clr();
      check("R5 both-alarm clear selects input 0", mux_sel, 1'b0);
      check("R5 indicator input 0", ref_ind, 1'b0);
      check("R5 alarms released", alarm0_n & alarm1_n, 1'b1);
      wait_cyc(30);
      check("R5 input 0 held in auto", mux_sel, 1'b0);

      // R7 manual prim change moves reference within 6 cycles
      auto_mode = 1'b0;
      prim_sel = 1'b0;
      wait_cyc(10);
      prim_sel = 1'b1;
      wait_cyc(6);
      check("R7 manual prim change", mux_sel, 1'b1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule